// File: doc/BRIEF.md
# Raster Line Fetch Engine

This block moves one raster frame from memory into a local pixel FIFO, one line at a time, for a display output stage to drain. A frame-start pulse captures the frame's geometry: the address where the first line starts, the length of each line in bytes, the number of lines, and a signed byte distance between the starts of consecutive lines. Negative distances walk up through memory for bottom-up images. Within each line the engine issues read bursts of 64-bit beats on a simple request/response memory port.

Each burst is sized by a programmable beat count and trimmed so that it never runs past the end of its line. The number of bursts in flight is held under a programmable cap. A burst is issued only when the FIFO can already take every beat that is still owed to it. Responses come back in request order and are written into the FIFO.

The display side can report an underrun, which ends fetching for the rest of the frame. An abort cancels the frame and throws away data still in flight. A frame-start that arrives while a frame is still busy does the same to the old frame and then begins the new one. A one-cycle event marks the end of a completed frame, and another marks each error response.

Top module: `fb_line_fetch`

## Requirements
- R1: On `frame_start` the engine captures its configuration. Line k (k = 0, 1, ...) starts at `cfg_base + k*cfg_pitch`, where the pitch is a two's-complement 32-bit byte offset and addresses wrap modulo 2^32. Each line is `cfg_len` bytes, a multiple of 8, fetched as ascending 8-byte beats. Every beat leaves `pix_data` in fetch order, with `pix_data` equal to the 64-bit response word.
- R2: A burst carries min(B, beats left in the line) beats, where B is `cfg_burst` with 0 read as 1 and values above 16 read as 16. `req_addr` is the byte address of the burst's first beat. No burst crosses a line end.
- R3: Requests of the current frame that are still awaiting their last response beat never outnumber `cfg_cap`, with 0 read as 1.
- R4: A request is issued only when FIFO occupancy plus all beats still owed by memory plus the new burst fit within the FIFO depth. The FIFO therefore never overflows, even when `pix_ready` is slow.
- R5: An `underrun` pulse while requests are still being issued stops all further requests until the next `frame_start`. Data already in flight is still delivered, `dma_end` does not fire for that frame, and the next frame fetches normally.
- R6: An `abort` pulse empties the FIFO, so `pix_valid` is low in the following cycle. It also discards every response beat still owed to earlier requests and stops further requests until the next `frame_start`.
- R7: A `frame_start` during a busy frame cancels the old frame as an abort does, in the same cycle. The new frame's beats are the only ones delivered afterwards.
- R8: `dma_end` is a one-cycle pulse once every request of the frame has been issued and its last response beat has arrived. With a line count of 0 or a line length below 8 bytes, `dma_end` pulses without any request being made.
- R9: A response beat of the live frame with `rsp_err` high gives a one-cycle `bus_err` pulse in the next cycle. That beat is not written to the FIFO, and fetching continues.
- R10: After reset `req_valid`, `pix_valid`, `dma_end` and `bus_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | Pulse: capture configuration and begin a frame |
| abort | input | 1 | Pulse: cancel the current frame |
| underrun | input | 1 | Pulse from the display side: stop fetching for this frame |
| cfg_base | input | 32 | Byte address of the first line |
| cfg_len | input | 16 | Line length in bytes (multiple of 8) |
| cfg_lines | input | 12 | Number of lines in the frame |
| cfg_pitch | input | 32 | Signed byte offset between line starts |
| cfg_burst | input | 5 | Beats per burst request |
| cfg_cap | input | 4 | Maximum requests in flight |
| req_valid | output | 1 | Read request valid |
| req_ready | input | 1 | Memory accepts the request |
| req_addr | output | 32 | Byte address of the burst's first beat |
| req_beats | output | 5 | Number of 8-byte beats in the burst |
| rsp_valid | input | 1 | Response beat valid |
| rsp_data | input | 64 | Response data |
| rsp_last | input | 1 | Last beat of a burst |
| rsp_err | input | 1 | Response beat carries an error |
| pix_valid | output | 1 | FIFO holds a beat |
| pix_ready | input | 1 | Display side takes a beat |
| pix_data | output | 64 | Oldest FIFO beat |
| dma_end | output | 1 | Pulse: frame fetch complete |
| bus_err | output | 1 | Pulse: error response seen |

## Verification
The bench builds the block with its defaults: a 32-entry FIFO, 16-bit line length and 12-bit line count. With that depth only two full 16-beat bursts can be reserved at once, so a slowly drained frame with clamped 16-beat bursts keeps the room gate closing and opening. Caps of 1, 4 and 15, a negative pitch, lines whose beat count leaves a short last burst, and memory latencies long enough for an abort, restart or underrun to land with bursts in flight are all reachable without large frames.

// File: rtl/fbf_pkg.sv
package fbf_pkg;
  localparam int ADDR_W     = 32;
  localparam int BEAT_SHIFT = 3;   // 8-byte beats
  localparam int MAX_BURST  = 16;
  localparam int BURST_W    = 5;
  localparam int CAP_W      = 4;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_RUN  = 2'd1,
    SQ_WAIT = 2'd2
  } seq_st_e;

  // Burst size as programmed, clamped into 1..MAX_BURST.
  function automatic logic [BURST_W-1:0] eff_burst(input logic [BURST_W-1:0] b);
    if (b == '0) return BURST_W'(1);
    if (b > BURST_W'(MAX_BURST)) return BURST_W'(MAX_BURST);
    return b;
  endfunction

  // In-flight cap as programmed, zero read as one.
  function automatic logic [CAP_W-1:0] eff_cap(input logic [CAP_W-1:0] c);
    return (c == '0) ? CAP_W'(1) : c;
  endfunction

  // Byte address of a beat within a line.
  function automatic logic [ADDR_W-1:0] beat_addr(input logic [ADDR_W-1:0] line_start,
                                                 input logic [ADDR_W-1:0] beat_idx);
    return line_start + (beat_idx << BEAT_SHIFT);
  endfunction
endpackage

// File: rtl/fbf_fifo.sv
module fbf_fifo #(
  parameter int DEPTH = 32,
  parameter int W     = 64,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [W-1:0]     din,
  input  logic             pop,
  output logic             valid,
  output logic [W-1:0]     dout,
  output logic [LVL_W-1:0] count
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             do_pop;

  assign valid  = (count != '0);
  assign do_pop = pop && valid;
  assign dout   = mem[rd_ptr];

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push)   wr_ptr <= nxt(wr_ptr);
      if (do_pop) rd_ptr <= nxt(rd_ptr);
      count <= count + LVL_W'(push) - LVL_W'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wr_ptr] <= din;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !flush) |-> (32'(count) < DEPTH || do_pop)); // R4
endmodule

// File: rtl/fbf_track.sv
module fbf_track import fbf_pkg::*; #(
  parameter int LVL_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               kill,
  input  logic               issue,
  input  logic [BURST_W-1:0] issue_beats,
  input  logic               rsp_valid,
  input  logic               rsp_last,
  input  logic [CAP_W-1:0]   cap_eff,
  output logic               below_cap,
  output logic               live_idle,
  output logic               dropping,
  output logic [LVL_W-1:0]   pending
);
  localparam int OC_W = CAP_W + 1;

  logic [OC_W-1:0] out_cnt, drop_cnt, out_nxt, live_cnt;
  logic            last_fire;

  assign last_fire = rsp_valid && rsp_last;
  assign out_nxt   = out_cnt + OC_W'(issue) - OC_W'(last_fire);
  assign dropping  = (drop_cnt != '0);
  assign live_cnt  = out_cnt - drop_cnt;
  assign live_idle = (live_cnt == '0);
  assign below_cap = (out_cnt < OC_W'(cap_eff));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_cnt  <= '0;
      drop_cnt <= '0;
      pending  <= '0;
    end else begin
      out_cnt <= out_nxt;
      // Everything owed at a kill belongs to the cancelled frame.
      if (kill) drop_cnt <= out_nxt;
      else      drop_cnt <= drop_cnt - OC_W'(last_fire && dropping);
      pending <= pending + (issue ? LVL_W'(issue_beats) : '0) - LVL_W'(rsp_valid);
    end
  end

  AST_LIVE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    live_cnt <= OC_W'(cap_eff)); // R3
  AST_DROP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    drop_cnt <= out_cnt); // R6
endmodule

// File: rtl/fbf_seq.sv
module fbf_seq import fbf_pkg::*; #(
  parameter int LEN_W = 16,
  parameter int CNT_W = 12,
  parameter int LVL_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_start,
  input  logic               abort,
  input  logic               underrun,
  input  logic [ADDR_W-1:0]  cfg_base,
  input  logic [LEN_W-1:0]   cfg_len,
  input  logic [CNT_W-1:0]   cfg_lines,
  input  logic [ADDR_W-1:0]  cfg_pitch,
  input  logic [BURST_W-1:0] cfg_burst,
  input  logic [CAP_W-1:0]   cfg_cap,
  input  logic               below_cap,
  input  logic [LVL_W-1:0]   fifo_space,
  input  logic               live_idle,
  input  logic               req_ready,
  output logic               req_valid,
  output logic [ADDR_W-1:0]  req_addr,
  output logic [BURST_W-1:0] req_beats,
  output logic               issue,
  output logic [CAP_W-1:0]   cap_eff,
  output logic               dma_end
);
  localparam int BEAT_W = LEN_W - BEAT_SHIFT;

  seq_st_e            st;
  logic [ADDR_W-1:0]  line_start, pitch_q;
  logic [BEAT_W-1:0]  line_beats, beat_off, remaining;
  logic [CNT_W-1:0]   lines_q, line_idx;
  logic [BURST_W-1:0] burst_q, burst_now;
  logic               line_done;
  logic [BEAT_W-1:0]  cfg_beats;

  assign cfg_beats = cfg_len[LEN_W-1:BEAT_SHIFT];
  assign remaining = line_beats - beat_off;
  assign burst_now = (remaining < BEAT_W'(burst_q)) ? BURST_W'(remaining) : burst_q;
  assign line_done = (beat_off + BEAT_W'(burst_now)) == line_beats;

  assign req_valid = (st == SQ_RUN) && below_cap && (fifo_space >= LVL_W'(burst_now));
  assign req_beats = burst_now;
  assign req_addr  = beat_addr(line_start, ADDR_W'(beat_off));
  assign issue     = req_valid && req_ready;
  assign dma_end   = (st == SQ_WAIT) && live_idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= SQ_IDLE;
      line_start <= '0;
      pitch_q    <= '0;
      line_beats <= '0;
      beat_off   <= '0;
      lines_q    <= '0;
      line_idx   <= '0;
      burst_q    <= BURST_W'(8);
      cap_eff    <= CAP_W'(4);
    end else if (frame_start) begin
      line_start <= cfg_base;
      pitch_q    <= cfg_pitch;
      line_beats <= cfg_beats;
      lines_q    <= cfg_lines;
      line_idx   <= '0;
      beat_off   <= '0;
      burst_q    <= eff_burst(cfg_burst);
      cap_eff    <= eff_cap(cfg_cap);
      st         <= (cfg_lines == '0 || cfg_beats == '0) ? SQ_WAIT : SQ_RUN;
    end else if (abort) begin
      st <= SQ_IDLE;
    end else if (underrun && st == SQ_RUN) begin
      st <= SQ_IDLE;
    end else if (issue) begin
      if (line_done) begin
        beat_off   <= '0;
        line_start <= line_start + pitch_q;
        line_idx   <= line_idx + CNT_W'(1);
        if (line_idx == lines_q - CNT_W'(1)) st <= SQ_WAIT;
      end else begin
        beat_off <= beat_off + BEAT_W'(burst_now);
      end
    end else if (dma_end) begin
      st <= SQ_IDLE;
    end
  end

  AST_LINE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (32'(beat_off) + 32'(req_beats)) <= 32'(line_beats)); // R2
  AST_BURST_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_beats != '0 && 32'(req_beats) <= MAX_BURST)); // R2
  AST_UNDERRUN_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun && !frame_start) |=> !req_valid); // R5
endmodule

// File: rtl/fb_line_fetch.sv
module fb_line_fetch import fbf_pkg::*; #(
  parameter int LEN_W  = 16,
  parameter int CNT_W  = 12,
  parameter int DEPTH  = 32,
  parameter int DATA_W = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_start,
  input  logic               abort,
  input  logic               underrun,
  input  logic [ADDR_W-1:0]  cfg_base,
  input  logic [LEN_W-1:0]   cfg_len,
  input  logic [CNT_W-1:0]   cfg_lines,
  input  logic [ADDR_W-1:0]  cfg_pitch,
  input  logic [BURST_W-1:0] cfg_burst,
  input  logic [CAP_W-1:0]   cfg_cap,
  output logic               req_valid,
  input  logic               req_ready,
  output logic [ADDR_W-1:0]  req_addr,
  output logic [BURST_W-1:0] req_beats,
  input  logic               rsp_valid,
  input  logic [DATA_W-1:0]  rsp_data,
  input  logic               rsp_last,
  input  logic               rsp_err,
  output logic               pix_valid,
  input  logic               pix_ready,
  output logic [DATA_W-1:0]  pix_data,
  output logic               dma_end,
  output logic               bus_err
);
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic             kill, issue, below_cap, live_idle, dropping, push;
  logic [CAP_W-1:0] cap_eff;
  logic [LVL_W-1:0] pending, fifo_count, fifo_space;

  assign kill       = frame_start || abort;
  assign push       = rsp_valid && !dropping && !rsp_err;
  assign fifo_space = LVL_W'(DEPTH) - fifo_count - pending;

  fbf_seq #(.LEN_W(LEN_W), .CNT_W(CNT_W), .LVL_W(LVL_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .abort(abort),
    .underrun(underrun), .cfg_base(cfg_base), .cfg_len(cfg_len),
    .cfg_lines(cfg_lines), .cfg_pitch(cfg_pitch), .cfg_burst(cfg_burst),
    .cfg_cap(cfg_cap), .below_cap(below_cap), .fifo_space(fifo_space),
    .live_idle(live_idle), .req_ready(req_ready), .req_valid(req_valid),
    .req_addr(req_addr), .req_beats(req_beats), .issue(issue),
    .cap_eff(cap_eff), .dma_end(dma_end)
  );

  fbf_track #(.LVL_W(LVL_W)) u_track (
    .clk(clk), .rst_n(rst_n), .kill(kill), .issue(issue),
    .issue_beats(req_beats), .rsp_valid(rsp_valid), .rsp_last(rsp_last),
    .cap_eff(cap_eff), .below_cap(below_cap), .live_idle(live_idle),
    .dropping(dropping), .pending(pending)
  );

  fbf_fifo #(.DEPTH(DEPTH), .W(DATA_W), .LVL_W(LVL_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(kill), .push(push), .din(rsp_data),
    .pop(pix_ready), .valid(pix_valid), .dout(pix_data), .count(fifo_count)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_err <= 1'b0;
    else        bus_err <= rsp_valid && rsp_err && !dropping;
  end

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(fifo_count) + 32'(pending)) <= DEPTH); // R4
  AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !pix_valid); // R6
  AST_RESTART_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !pix_valid); // R7
  AST_DMA_END_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    dma_end |=> !dma_end); // R8
endmodule

// File: tb/fb_line_fetch_bench.sv
`timescale 1ns/1ps
module fb_line_fetch_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        frame_start = 1'b0, abort = 1'b0, underrun = 1'b0;
  logic [31:0] cfg_base = '0, cfg_pitch = '0;
  logic [15:0] cfg_len = '0;
  logic [11:0] cfg_lines = '0;
  logic [4:0]  cfg_burst = '0;
  logic [3:0]  cfg_cap = '0;
  logic        req_valid, req_ready = 1'b0;
  logic [31:0] req_addr;
  logic [4:0]  req_beats;
  logic        rsp_valid = 1'b0, rsp_last = 1'b0, rsp_err = 1'b0;
  logic [63:0] rsp_data = '0;
  logic        pix_valid, pix_ready = 1'b0;
  logic [63:0] pix_data;
  logic        dma_end, bus_err;

  fb_line_fetch u_fb_line_fetch (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .abort(abort),
    .underrun(underrun), .cfg_base(cfg_base), .cfg_len(cfg_len),
    .cfg_lines(cfg_lines), .cfg_pitch(cfg_pitch), .cfg_burst(cfg_burst),
    .cfg_cap(cfg_cap), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_beats(req_beats), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .rsp_last(rsp_last), .rsp_err(rsp_err),
    .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_data(pix_data),
    .dma_end(dma_end), .bus_err(bus_err)
  );

  typedef struct packed {
    logic [31:0] base;
    logic [15:0] len;
    logic [11:0] lines;
    logic [31:0] pitch;
    logic [4:0]  burst;
    logic [3:0]  cap;
    logic [3:0]  lat;
    logic [1:0]  rdy_mod;
    logic [1:0]  drain_mod;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{32'h0000_1000, 16'd64,  12'd3, 32'd128,       5'd8,  4'd4,  4'd2, 2'd0, 2'd0},
    '{32'h0000_8000, 16'd40,  12'd4, 32'hFFFF_FF00, 5'd2,  4'd1,  4'd5, 2'd3, 2'd2},
    '{32'h0000_2000, 16'd200, 12'd2, 32'h0000_1000, 5'd20, 4'd15, 4'd3, 2'd0, 2'd3},
    '{32'h0000_0040, 16'd24,  12'd2, 32'd24,        5'd0,  4'd0,  4'd1, 2'd2, 2'd0},
    '{32'h0000_0500, 16'd0,   12'd5, 32'd8,         5'd4,  4'd4,  4'd1, 2'd0, 2'd0},
    '{32'h0000_0600, 16'd64,  12'd0, 32'd8,         5'd4,  4'd4,  4'd1, 2'd0, 2'd0}
  };
  localparam vec_t LONGV =
    '{32'h0001_0000, 16'd256, 12'd8, 32'd512, 5'd4, 4'd4, 4'd12, 2'd0, 2'd0};

  int checks = 0, fails = 0;
  bit finished = 0;

  // memory model and monitors
  int          cyc = 0;
  int          lat_cur = 1, rdy_mod = 0, drain_mod = 0, err_at = -1, beat_ctr = 0;
  logic [31:0] q_addr[$];
  int          q_beats[$], q_due[$];
  int          rb = 0;
  logic [31:0] e_raddr[$];
  int          e_rbeats[$];
  logic [63:0] e_pix[$];
  bit          cmp_en = 0;
  int          req_seen = 0, pix_seen = 0, req_bad = 0, pix_bad = 0;
  int          dma_seen = 0, berr_seen = 0, bo = 0, bo_max = 0, beats_acc = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      // response beat for the next edge
      if (q_addr.size() != 0 && q_due[0] <= cyc) begin
        logic [31:0] a;
        a = q_addr[0] + 32'(rb * 8);
        rsp_valid = 1'b1;
        rsp_data  = {~a, a};
        rsp_last  = (rb == q_beats[0] - 1);
        rsp_err   = (beat_ctr == err_at);
        beat_ctr++;
        if (rsp_last) begin
          void'(q_addr.pop_front()); void'(q_beats.pop_front()); void'(q_due.pop_front());
          rb = 0;
          bo--;
        end else rb++;
      end else begin
        rsp_valid = 1'b0; rsp_last = 1'b0; rsp_err = 1'b0;
      end
      // request acceptance
      req_ready = (rdy_mod == 0 || (cyc % rdy_mod) != 0) && !frame_start && !abort;
      if (req_valid && req_ready) begin
        q_addr.push_back(req_addr); q_beats.push_back(int'(req_beats));
        q_due.push_back(cyc + lat_cur);
        req_seen++; beats_acc += int'(req_beats);
        bo++; if (bo > bo_max) bo_max = bo;
        if (cmp_en) begin
          if (e_raddr.size() == 0 || e_raddr[0] != req_addr || e_rbeats[0] != int'(req_beats)) begin
            req_bad++;
            $display("  request mismatch addr=%h beats=%0d", req_addr, req_beats);
          end
          if (e_raddr.size() != 0) begin void'(e_raddr.pop_front()); void'(e_rbeats.pop_front()); end
        end
      end
      // pixel drain
      pix_ready = (drain_mod == 0 || (cyc % drain_mod) != 0) && !frame_start && !abort;
      if (pix_valid && pix_ready) begin
        pix_seen++;
        if (cmp_en) begin
          if (e_pix.size() == 0 || e_pix[0] != pix_data) begin
            pix_bad++;
            $display("  pixel mismatch data=%h", pix_data);
          end
          if (e_pix.size() != 0) void'(e_pix.pop_front());
        end
      end
      if (dma_end) dma_seen++;
      if (bus_err) berr_seen++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int eff_b(input logic [4:0] b);
    return (b == 0) ? 1 : (b > 16) ? 16 : int'(b);
  endfunction

  // Build expectations and pulse frame_start; stimulus changes just after posedge.
  task automatic start_frame(input vec_t v, input bit cmp);
    int nbeats, bb;
    @(posedge clk); #1;
    cfg_base = v.base; cfg_len = v.len; cfg_lines = v.lines; cfg_pitch = v.pitch;
    cfg_burst = v.burst; cfg_cap = v.cap;
    lat_cur = int'(v.lat); rdy_mod = int'(v.rdy_mod); drain_mod = int'(v.drain_mod);
    e_raddr.delete(); e_rbeats.delete(); e_pix.delete();
    nbeats = int'(v.len) / 8;
    bb = eff_b(v.burst);
    for (int l = 0; l < int'(v.lines); l++) begin
      logic [31:0] ls;
      int off;
      ls = v.base + 32'(l) * v.pitch;
      off = 0;
      while (off < nbeats) begin
        int n;
        n = (nbeats - off < bb) ? nbeats - off : bb;
        e_raddr.push_back(ls + 32'(off * 8)); e_rbeats.push_back(n);
        off += n;
      end
      for (int k = 0; k < nbeats; k++) begin
        logic [31:0] a;
        a = ls + 32'(k * 8);
        e_pix.push_back({~a, a});
      end
    end
    req_seen = 0; pix_seen = 0; req_bad = 0; pix_bad = 0; dma_seen = 0;
    berr_seen = 0; bo_max = 0; beats_acc = 0;
    cmp_en = cmp;
    frame_start = 1'b1;
    @(posedge clk); #1;
    frame_start = 1'b0;
  endtask

  task automatic wait_done(input bit cmp);
    int w;
    w = 0;
    while (!(dma_seen > 0 && (!cmp || e_pix.size() == 0)) && w < 6000) begin
      @(posedge clk); w++;
    end
    repeat (6) @(posedge clk);
    #1;
  endtask

  task automatic pulse(input int which);
    @(posedge clk); #1;
    if (which == 0) underrun = 1'b1; else abort = 1'b1;
    @(posedge clk); #1;
    underrun = 1'b0; abort = 1'b0;
  endtask

  initial begin
    int snap_req, snap_pix, total;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(req_valid == 0, "R10", "req_valid after reset", req_valid, 0);
    chk(pix_valid == 0, "R10", "pix_valid after reset", pix_valid, 0);
    chk(dma_end == 0,   "R10", "dma_end after reset", dma_end, 0);
    chk(bus_err == 0,   "R10", "bus_err after reset", bus_err, 0);

    // table-driven frames
    for (int i = 0; i < NVEC; i++) begin
      int capx;
      start_frame(VECS[i], 1);
      wait_done(1);
      capx = (VECS[i].cap == 0) ? 1 : int'(VECS[i].cap);
      chk(pix_bad == 0 && e_pix.size() == 0, "R1", "pixel order mismatches/left",
          pix_bad + e_pix.size(), 0);
      chk(req_bad == 0 && e_raddr.size() == 0, "R2", "burst split mismatches/left",
          req_bad + e_raddr.size(), 0);
      chk(bo_max <= capx, "R3", "max requests in flight", bo_max, capx);  // R4 via slow drain
      chk(dma_seen == 1, "R8", "dma_end pulses", dma_seen, 1);
      if (VECS[i].len == 0 || VECS[i].lines == 0)
        chk(req_seen == 0, "R8", "requests on empty frame", req_seen, 0);
    end

    // R5: underrun mid-frame
    start_frame(LONGV, 0);
    repeat (40) @(posedge clk);
    pulse(0);
    @(posedge clk); #1;
    snap_req = req_seen;
    repeat (300) @(posedge clk); #1;
    chk(req_seen == snap_req, "R5", "requests after underrun", req_seen, snap_req);
    chk(dma_seen == 0, "R5", "dma_end after underrun", dma_seen, 0);
    chk(pix_seen == beats_acc, "R5", "in-flight beats delivered", pix_seen, beats_acc);
    start_frame(VECS[0], 1);
    wait_done(1);
    chk(pix_bad == 0 && e_pix.size() == 0 && dma_seen == 1, "R5", "frame after underrun",
        pix_bad + e_pix.size(), 0);

    // R6: abort with bursts in flight
    start_frame(LONGV, 0);
    repeat (30) @(posedge clk);
    pulse(1);
    #1;
    snap_req = req_seen; snap_pix = pix_seen;
    repeat (250) @(posedge clk); #1;
    chk(pix_seen == snap_pix, "R6", "beats delivered after abort", pix_seen, snap_pix);
    chk(req_seen == snap_req, "R6", "requests after abort", req_seen, snap_req);
    chk(dma_seen == 0, "R6", "dma_end after abort", dma_seen, 0);
    start_frame(VECS[1], 1);
    wait_done(1);
    chk(pix_bad == 0 && e_pix.size() == 0, "R6", "frame after abort",
        pix_bad + e_pix.size(), 0);

    // R7: restart while busy, old responses still owed
    start_frame(LONGV, 0);
    repeat (25) @(posedge clk);
    start_frame(VECS[2], 1);
    wait_done(1);
    chk(pix_bad == 0 && e_pix.size() == 0, "R7", "restart pixel stream",
        pix_bad + e_pix.size(), 0);
    chk(req_bad == 0 && e_raddr.size() == 0, "R7", "restart requests",
        req_bad + e_raddr.size(), 0);
    chk(dma_seen == 1, "R7", "restart dma_end", dma_seen, 1);

    // R9: one error beat
    repeat (200) @(posedge clk);
    beat_ctr = 0; err_at = 3;
    start_frame(VECS[0], 0);
    wait_done(0);
    err_at = -1;
    total = (int'(VECS[0].len) / 8) * int'(VECS[0].lines);
    chk(berr_seen == 1, "R9", "bus_err pulses", berr_seen, 1);
    chk(pix_seen == total - 1, "R9", "beats delivered with error", pix_seen, total - 1);
    chk(dma_seen == 1, "R9", "dma_end with error", dma_seen, 1);

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog run did not end actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end
endmodule